// File: doc/BRIEF.md
# Bit-Oriented HDLC Receive Deframer

This block recovers packets from a serial stream taken off one channel of a time-division bus. A new bit is offered whenever the bit strobe is high, and every bit is judged on its own, with no regard to byte alignment. The block hunts for the delimiter pattern `01111110`. Between two delimiters it drops the zero that a transmitter inserts after five consecutive ones. It packs the remaining payload bits into bytes, least significant bit first.

Bytes leave on a one-cycle strobe, and the first byte of each packet is marked. Each packet that carried any payload is closed by a separate end strobe. An error pulse beside that strobe marks the packet bad. A packet is bad if its payload was not a whole number of bytes, or if it was cut short by a run of seven or more ones. Such a run is also the idle code, and an idle status output reports it. One delimiter can close a packet and open the next one.

Top module: `hdlc_bit_deframer`

## Requirements
- R1: The byte `01111110` (0x7E) marks packet boundaries. The payload bits between an opening and a closing delimiter are output as bytes, and the first payload bit received becomes bit 0 of its byte.
- R2: Inside a packet, a 0 received right after five consecutive 1s is discarded and does not count as payload.
- R3: The first byte of a packet has `out_sop` high. A packet with at least one payload bit ends with a single-cycle `out_eop`, with `out_vld` low, after its last byte.
- R4: A single delimiter closes the current packet and opens the next one, and the next packet's bytes follow with no further delimiter.
- R5: Two or more delimiters with no payload bits between them produce no output at all.
- R6: If a closing delimiter follows a payload whose bit count is not a multiple of 8, `out_err` is high together with `out_eop`. All complete bytes are still delivered, and the partial byte is dropped.
- R7: `line_idle` goes high with the seventh consecutive 1 and stays high while 1s continue. It goes low with the next 0.
- R8: A run of seven 1s inside a packet that has already delivered payload bits ends that packet with `out_eop` and `out_err`, and drops the byte in progress. Bits that follow are ignored until the next delimiter. If no payload bits have been delivered yet, the packet is dropped silently.
- R9: Before the first delimiter, and after an abort, no input bit produces any output.
- R10: Outputs are registered. A result appears in the cycle after the clock edge that samples the bit causing it, and cycles with `bit_vld` low change nothing.
- R11: While `rst_n` is low, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Line bit strobe; `bit_in` is taken when high |
| bit_in | input | 1 | Line bit |
| out_vld | output | 1 | Payload byte strobe |
| out_byte | output | 8 | Payload byte, valid with `out_vld` |
| out_sop | output | 1 | First byte of a packet, with `out_vld` |
| out_eop | output | 1 | Packet end strobe, never together with `out_vld` |
| out_err | output | 1 | Packet bad, only with `out_eop` |
| line_idle | output | 1 | Seven or more consecutive 1s seen |

## Verification
The hardest case to reach is an abort that hits a packet partway through. The line carries the packet's last seven received bits in the delimiter look-ahead, and these must be thrown away. A correct transmitter never sends such a run, so random framed traffic does not produce it. The stimulus therefore bypasses the bench's stuffing encoder and sends seven raw ones after a payload whose last bit is 0. The expected output is then worked out by hand: two bytes, a bad end, and a clean recovery on the following packet. The same bypass produces payloads of 3 and 12 bits to exercise the length-error path, and a delimiter followed directly by an abort to show that such a packet is dropped silently.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  // Meaning of one sampled line bit after run-length classification
  typedef enum logic [2:0] {
    SYM_NONE,   // no bit this cycle
    SYM_DATA,   // ordinary bit, value on the line
    SYM_STUFF,  // inserted zero, drop it
    SYM_FLAG,   // final zero of a delimiter
    SYM_ABORT   // seventh one in a row
  } sym_t;
endpackage

// File: rtl/hdlc_rx_run.sv
module hdlc_rx_run
  import hdlc_rx_pkg::*;
#(
  parameter int STUFF_RUN = 5,
  parameter int FLAG_ONES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  output sym_t sym,
  output logic line_idle
);
  localparam int IDLE_RUN = FLAG_ONES + 1;
  localparam int CNT_W    = $clog2(IDLE_RUN + 1);
  localparam logic [CNT_W-1:0] STUFF_C = CNT_W'(STUFF_RUN);
  localparam logic [CNT_W-1:0] FLAG_C  = CNT_W'(FLAG_ONES);
  localparam logic [CNT_W-1:0] IDLE_C  = CNT_W'(IDLE_RUN);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    sym   = SYM_NONE;
    if (bit_vld) begin
      sym = SYM_DATA;
      if (bit_in) begin
        if (cnt_q != IDLE_C) cnt_d = cnt_q + 1'b1;
        if (cnt_q == FLAG_C) sym = SYM_ABORT;
      end else begin
        cnt_d = '0;
        if (cnt_q == STUFF_C)     sym = SYM_STUFF;
        else if (cnt_q == FLAG_C) sym = SYM_FLAG;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign line_idle = (cnt_q == IDLE_C);
endmodule

// File: rtl/hdlc_rx_tail.sv
module hdlc_rx_tail #(
  parameter int DEPTH = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic push_bit,
  input  logic flush,
  output logic pop_vld,
  output logic pop_bit
);
  localparam int FW = $clog2(DEPTH + 1);
  localparam logic [FW-1:0] FULL_C = FW'(DEPTH);

  logic [DEPTH-1:0] sr_q, sr_d;
  logic [FW-1:0]    fill_q, fill_d;
  logic             full;

  assign full    = (fill_q == FULL_C);
  assign pop_vld = push && full && !flush;
  assign pop_bit = sr_q[DEPTH-1];

  always_comb begin
    sr_d   = sr_q;
    fill_d = fill_q;
    if (flush) begin
      fill_d = '0;
    end else if (push) begin
      sr_d = {sr_q[DEPTH-2:0], push_bit};
      if (!full) fill_d = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      fill_q <= '0;
    end else begin
      sr_q   <= sr_d;
      fill_q <= fill_d;
    end
  end
endmodule

// File: rtl/hdlc_rx_frame.sv
module hdlc_rx_frame
  import hdlc_rx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sym_t              sym,
  input  logic              pop_vld,
  input  logic              pop_bit,
  output logic              push,
  output logic              flush,
  output logic              out_vld,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_err
);
  localparam int NW = $clog2(BYTE_W);
  localparam logic [NW-1:0] LAST_C = NW'(BYTE_W - 1);

  logic              in_frame_q, in_frame_d;
  logic [BYTE_W-1:0] acc_q, acc_d;
  logic [NW-1:0]     nbit_q, nbit_d;
  logic              any_q, any_d;
  logic              first_q, first_d;
  logic              vld_q, vld_d, sop_q, sop_d, eop_q, eop_d, err_q, err_d;
  logic [BYTE_W-1:0] byte_q, byte_d;

  always_comb begin
    in_frame_d = in_frame_q;
    acc_d      = acc_q;
    nbit_d     = nbit_q;
    any_d      = any_q;
    first_d    = first_q;
    byte_d     = byte_q;
    vld_d      = 1'b0;
    sop_d      = 1'b0;
    eop_d      = 1'b0;
    err_d      = 1'b0;
    push       = in_frame_q && (sym == SYM_DATA);
    flush      = (sym == SYM_FLAG) || (sym == SYM_ABORT);

    if (pop_vld) begin
      acc_d = {pop_bit, acc_q[BYTE_W-1:1]};
      any_d = 1'b1;
      if (nbit_q == LAST_C) begin
        vld_d   = 1'b1;
        byte_d  = acc_d;
        sop_d   = first_q;
        first_d = 1'b0;
        nbit_d  = '0;
      end else begin
        nbit_d = nbit_q + 1'b1;
      end
    end

    if (sym == SYM_FLAG) begin
      if (in_frame_q && any_q) begin
        eop_d = 1'b1;
        err_d = (nbit_q != '0);
      end
      in_frame_d = 1'b1;
      any_d      = 1'b0;
      nbit_d     = '0;
      first_d    = 1'b1;
    end else if (sym == SYM_ABORT) begin
      if (in_frame_q && any_q) begin
        eop_d = 1'b1;
        err_d = 1'b1;
      end
      in_frame_d = 1'b0;
      any_d      = 1'b0;
      nbit_d     = '0;
      first_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      acc_q      <= '0;
      nbit_q     <= '0;
      any_q      <= 1'b0;
      first_q    <= 1'b0;
      byte_q     <= '0;
      vld_q      <= 1'b0;
      sop_q      <= 1'b0;
      eop_q      <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      in_frame_q <= in_frame_d;
      acc_q      <= acc_d;
      nbit_q     <= nbit_d;
      any_q      <= any_d;
      first_q    <= first_d;
      byte_q     <= byte_d;
      vld_q      <= vld_d;
      sop_q      <= sop_d;
      eop_q      <= eop_d;
      err_q      <= err_d;
    end
  end

  assign out_vld  = vld_q;
  assign out_byte = byte_q;
  assign out_sop  = sop_q;
  assign out_eop  = eop_q;
  assign out_err  = err_q;
endmodule

// File: rtl/hdlc_bit_deframer.sv
module hdlc_bit_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int STUFF_RUN = 5,
  parameter int FLAG_ONES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              bit_in,
  output logic              out_vld,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_err,
  output logic              line_idle
);
  // Bits of a delimiter that arrive before its final zero
  localparam int TAIL_DEPTH = FLAG_ONES + 1;

  sym_t sym;
  logic push, flush, pop_vld, pop_bit;

  hdlc_rx_run #(
    .STUFF_RUN(STUFF_RUN),
    .FLAG_ONES(FLAG_ONES)
  ) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_vld  (bit_vld),
    .bit_in   (bit_in),
    .sym      (sym),
    .line_idle(line_idle)
  );

  hdlc_rx_tail #(
    .DEPTH(TAIL_DEPTH)
  ) u_tail (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (push),
    .push_bit(bit_in),
    .flush   (flush),
    .pop_vld (pop_vld),
    .pop_bit (pop_bit)
  );

  hdlc_rx_frame #(
    .BYTE_W(BYTE_W)
  ) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .sym     (sym),
    .pop_vld (pop_vld),
    .pop_bit (pop_bit),
    .push    (push),
    .flush   (flush),
    .out_vld (out_vld),
    .out_byte(out_byte),
    .out_sop (out_sop),
    .out_eop (out_eop),
    .out_err (out_err)
  );
endmodule

// File: rtl/hdlc_bit_deframer_chk.sv
module hdlc_bit_deframer_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_vld,
  input logic              bit_in,
  input logic              out_vld,
  input logic [BYTE_W-1:0] out_byte,
  input logic              out_sop,
  input logic              out_eop,
  input logic              out_err,
  input logic              line_idle
);
  a_r3_eop_alone: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |-> !out_vld);

  a_r3_sop_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> out_vld);

  a_r6_err_with_eop: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_eop);

  a_r7_idle_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_idle) |-> $past(bit_vld && bit_in));

  a_r7_idle_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_idle) |-> $past(bit_vld && !bit_in));

  a_r8_abort_at_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (out_err && line_idle) |-> $rose(line_idle));

  a_r10_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld || out_eop) |-> $past(bit_vld));

  a_r10_byte_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_vld) |-> $stable(out_byte));
endmodule

bind hdlc_bit_deframer hdlc_bit_deframer_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_vld  (bit_vld),
  .bit_in   (bit_in),
  .out_vld  (out_vld),
  .out_byte (out_byte),
  .out_sop  (out_sop),
  .out_eop  (out_eop),
  .out_err  (out_err),
  .line_idle(line_idle)
);

// File: tb/hdlc_bit_deframer_bench.sv
module hdlc_bit_deframer_bench;
  logic       clk;
  logic       rst_n;
  logic       bit_vld;
  logic       bit_in;
  logic       out_vld;
  logic [7:0] out_byte;
  logic       out_sop;
  logic       out_eop;
  logic       out_err;
  logic       line_idle;

  int         n_chk;
  int         n_err;
  int         tx_ones;
  int         max_gap;
  bit         done;
  bit [11:0]  got[$];
  bit [11:0]  exp[$];

  hdlc_bit_deframer u_hdlc_bit_deframer (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .out_vld(out_vld), .out_byte(out_byte), .out_sop(out_sop),
    .out_eop(out_eop), .out_err(out_err), .line_idle(line_idle)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Event log: {vld, eop, err, sop, byte}
  always @(negedge clk)
    if (rst_n && (out_vld || out_eop))
      got.push_back({out_vld, out_eop, out_err, out_sop, out_vld ? out_byte : 8'h00});

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic send_bit(input bit b);
    int gap;
    gap = (max_gap > 0) ? int'($urandom_range(0, max_gap)) : 0;
    repeat (gap) @(posedge clk);
    #1;
    bit_vld = 1'b1;
    bit_in  = b;
    @(posedge clk);
    #1;
    bit_vld = 1'b0;
  endtask

  task automatic send_data(input bit b);
    send_bit(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin
        send_bit(1'b0);
        tx_ones = 0;
      end
    end else begin
      tx_ones = 0;
    end
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_data(v[i]);
  endtask

  task automatic send_flag();
    send_bit(1'b0);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    send_bit(1'b0);
    tx_ones = 0;
  endtask

  task automatic exp_byte(input logic [7:0] v, input bit sop);
    exp.push_back({1'b1, 1'b0, 1'b0, sop, v});
  endtask

  task automatic exp_end(input bit err);
    exp.push_back({1'b0, 1'b1, err, 1'b0, 8'h00});
  endtask

  task automatic compare(input string tag);
    int n;
    repeat (3) @(posedge clk);
    #1;
    chk(got.size() == exp.size(), tag, "event count", got.size(), exp.size());
    n = (got.size() < exp.size()) ? got.size() : exp.size();
    for (int i = 0; i < n; i++)
      chk(got[i] == exp[i], tag, $sformatf("event %0d", i), int'(got[i]), int'(exp[i]));
    got.delete();
    exp.delete();
  endtask

  function automatic logic [7:0] pick_byte();
    int r;
    r = int'($urandom_range(0, 3));
    if (r == 0) return 8'hFF;
    if (r == 1) return 8'h7E;
    return 8'($urandom);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    logic [7:0] q[$];
    int nb;
    void'($urandom(32'd2024));
    done    = 1'b0;
    n_chk   = 0;
    n_err   = 0;
    tx_ones = 0;
    max_gap = 0;
    rst_n   = 1'b0;
    bit_vld = 1'b0;
    bit_in  = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk({out_vld, out_sop, out_eop, out_err, line_idle} == 5'b0, "R11", "outputs in reset",
        int'({out_vld, out_sop, out_eop, out_err, line_idle}), 0);
    chk(out_byte == 8'h00, "R11", "byte in reset", out_byte, 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;

    // R9 hunting: no delimiter yet, alternating bits and a stuff-like run
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < 8; i++) send_bit(i[0]);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    send_bit(1'b0);
    compare("R9");

    // R7 idle status
    send_bit(1'b0);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    chk(line_idle == 1'b0, "R7", "idle after six ones", line_idle, 0);
    send_bit(1'b1);
    chk(line_idle == 1'b1, "R7", "idle after seven ones", line_idle, 1);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    chk(line_idle == 1'b1, "R7", "idle held", line_idle, 1);
    send_bit(1'b0);
    chk(line_idle == 1'b0, "R7", "idle cleared by zero", line_idle, 0);
    compare("R7");

    // R1 bit order
    send_flag();
    send_byte(8'h01); exp_byte(8'h01, 1'b1);
    send_byte(8'h80); exp_byte(8'h80, 1'b0);
    send_flag();      exp_end(1'b0);
    compare("R1");

    // R2 zero removal on ones-heavy payload
    send_flag();
    send_byte(8'hFF); exp_byte(8'hFF, 1'b1);
    send_byte(8'hFF); exp_byte(8'hFF, 1'b0);
    send_byte(8'h7E); exp_byte(8'h7E, 1'b0);
    send_byte(8'h7D); exp_byte(8'h7D, 1'b0);
    send_byte(8'h1F); exp_byte(8'h1F, 1'b0);
    send_byte(8'hF8); exp_byte(8'hF8, 1'b0);
    send_flag();      exp_end(1'b0);
    compare("R2");

    // R6 short payload, R10 timing of the end strobe, R4 shared delimiter
    send_flag();
    send_data(1'b1); send_data(1'b0); send_data(1'b1);
    send_flag();
    chk(out_eop && out_err, "R10", "end strobe right after delimiter",
        int'({out_eop, out_err}), 3);
    @(posedge clk);
    #1;
    chk(!out_eop, "R10", "end strobe one cycle", out_eop, 0);
    exp_end(1'b1);
    send_byte(8'hC3); exp_byte(8'hC3, 1'b1);
    send_data(1'b0); send_data(1'b1); send_data(1'b1); send_data(1'b1);
    send_flag();      exp_end(1'b1);
    compare("R6");

    // R5 empty packets
    send_flag(); send_flag(); send_flag();
    compare("R5");

    // R8 abort mid-packet, then recovery
    send_flag();
    send_byte(8'hA5); exp_byte(8'hA5, 1'b1);
    send_byte(8'h3C); exp_byte(8'h3C, 1'b0);
    send_byte(8'h11);
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    exp_end(1'b1);
    chk(line_idle == 1'b1, "R7", "idle on abort", line_idle, 1);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
    tx_ones = 0;
    send_flag();
    send_byte(8'h42); exp_byte(8'h42, 1'b1);
    send_flag();      exp_end(1'b0);
    compare("R8");

    // R8 abort right after opening delimiter is silent
    send_flag();
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    send_bit(1'b0);
    compare("R8 empty");

    // R3/R4 random traffic with gaps, shared and doubled delimiters
    max_gap = 2;
    send_flag();
    for (int f = 0; f < 40; f++) begin
      q.delete();
      nb = int'($urandom_range(1, 6));
      for (int i = 0; i < nb; i++) q.push_back(pick_byte());
      foreach (q[i]) begin
        send_byte(q[i]);
        exp_byte(q[i], i == 0);
      end
      send_flag();
      exp_end(1'b0);
      if ($urandom_range(0, 2) == 0) send_flag();
    end
    compare("R4 random");

    done = 1'b1;
    summary();
  end
endmodule